// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Store

This block keeps the tag, data and state storage of a direct-mapped write-back cache in synchronous on-chip arrays and answers one word-sized lookup at a time. A lookup carries a byte address, a load/store flag and a store word. The address is split into a tag, a line index and a word select. The lookup is classified against the resident line as a load hit, a store hit or a miss.

A load hit returns the addressed word. A store hit merges the word into the resident line and marks the line dirty. A miss returns the whole resident line with its stored tag and state, so that a surrounding controller can decide whether to write that line back before it refills the slot. The controller refills a slot through a separate update port, which overwrites the line, tag and state at any index. An update always wins over anything else that touches the same index in the same cycle.

Top module: `lsa_top`

## Requirements
- R1: After reset every line is invalid: any lookup at any index reports a miss with state code 0.
- R2: The address is split as follows: bits [1:0] are ignored, bits [5:2] select the 32-bit word in the 16-word line, the next INDEX_W bits select the line, and the remaining upper bits form the tag.
- R3: A lookup hits only when the line state is not invalid and the stored tag equals the address tag. Otherwise the response kind is 2 (miss).
- R4: A load hit reports kind 0 and returns in rsp_word_o the addressed word of the line, where word w occupies line bits [32w+31:32w].
- R5: A store hit reports kind 1 with rsp_word_o zero. When the response is consumed, the store word replaces the addressed word and the line state becomes dirty (code 2). No other word of the line changes, and no other line changes.
- R6: A miss reports the full resident line, its stored tag and its state (0 invalid, 1 clean, 2 dirty), with rsp_word_o zero.
- R7: An update writes the given line, tag and state at the given index, and later lookups see them.
- R8: req_ready_o is high only while no response is outstanding. The response for an accepted request is valid on the next cycle. It stays valid and unchanged until rsp_ready_i is seen high, unless an update hits its index. After that it drops.
- R9: An update to the index of the lookup in flight, or of a lookup being accepted, takes priority. The pending response is re-evaluated against the updated line, and a store-hit merge to that index in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request valid |
| req_ready_o | output | 1 | Block can accept a lookup |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address |
| req_data_i | input | WORD_W | Store word |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response consumed |
| rsp_kind_o | output | 2 | 0 load hit, 1 store hit, 2 miss |
| rsp_word_o | output | WORD_W | Loaded word (load hit only) |
| rsp_line_o | output | WORD_W*LINE_WORDS | Resident line |
| rsp_tag_o | output | TAG_W | Stored tag of the resident line |
| rsp_status_o | output | 2 | Resident line state |
| upd_valid_i | input | 1 | Update command |
| upd_index_i | input | INDEX_W | Line to overwrite |
| upd_line_i | input | WORD_W*LINE_WORDS | New line data |
| upd_tag_i | input | TAG_W | New tag |
| upd_status_i | input | 2 | New state |

## Verification
Every cycle, the assertions check the handshake: a response follows each acceptance, a response holds still while it waits when no update intervenes, and it drops once consumed. They also check that the response kind stays within its three codes, that a store hit carries no data word, and that a hit never reports an invalid line. Only the bench's scenarios can show that data is correct: words read back from every index and word position, the merged line and dirty state after a store, the resident line handed back on a miss, and which write survives when an update collides with a pending lookup or a store merge.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    LS_INVALID = 2'd0,
    LS_CLEAN   = 2'd1,
    LS_DIRTY   = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    RK_LD_HIT = 2'd0,
    RK_ST_HIT = 2'd1,
    RK_MISS   = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/lsa_addr_split.sv
module lsa_addr_split #(
  parameter int ADDR_W  = 32,
  parameter int BOFS_W  = 2,
  parameter int WSEL_W  = 4,
  parameter int INDEX_W = 4,
  localparam int TAG_W  = ADDR_W - INDEX_W - WSEL_W - BOFS_W
) (
  input  logic [ADDR_W-1:BOFS_W] waddr_i,
  output logic [TAG_W-1:0]       tag_o,
  output logic [INDEX_W-1:0]     index_o,
  output logic [WSEL_W-1:0]      wsel_o
);
  assign wsel_o  = waddr_i[BOFS_W +: WSEL_W];
  assign index_o = waddr_i[BOFS_W+WSEL_W +: INDEX_W];
  assign tag_o   = waddr_i[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/lsa_storage.sv
module lsa_storage #(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 22,
  parameter int LINE_W  = 512,
  localparam int NUM_LINES = 1 << INDEX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  // lookup read port
  input  logic               rd_en_i,
  input  logic [INDEX_W-1:0] rd_index_i,
  input  logic               pend_i,
  input  logic [INDEX_W-1:0] pend_index_i,
  output logic [LINE_W-1:0]  rd_line_o,
  output logic [TAG_W-1:0]   rd_tag_o,
  output logic [1:0]         rd_state_o,
  // store-hit merge
  input  logic               cmt_en_i,
  input  logic [INDEX_W-1:0] cmt_index_i,
  input  logic [LINE_W-1:0]  cmt_line_i,
  // update port, highest priority
  input  logic               upd_en_i,
  input  logic [INDEX_W-1:0] upd_index_i,
  input  logic [LINE_W-1:0]  upd_line_i,
  input  logic [TAG_W-1:0]   upd_tag_i,
  input  logic [1:0]         upd_state_i
);
  import lsa_pkg::*;

  logic [LINE_W-1:0] data_q  [NUM_LINES];
  logic [TAG_W-1:0]  tag_q   [NUM_LINES];
  logic [1:0]        state_q [NUM_LINES];

  // update is written last so it wins on an index collision
  always_ff @(posedge clk_i) begin
    if (cmt_en_i) data_q[cmt_index_i] <= cmt_line_i;
    if (upd_en_i) begin
      data_q[upd_index_i] <= upd_line_i;
      tag_q[upd_index_i]  <= upd_tag_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) state_q[i] <= LS_INVALID;
    end else begin
      if (cmt_en_i) state_q[cmt_index_i] <= LS_DIRTY;
      if (upd_en_i) state_q[upd_index_i] <= upd_state_i;
    end
  end

  logic upd_on_rd, upd_on_pend;
  assign upd_on_rd   = upd_en_i && (upd_index_i == rd_index_i);
  assign upd_on_pend = upd_en_i && pend_i && (upd_index_i == pend_index_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_line_o  <= '0;
      rd_tag_o   <= '0;
      rd_state_o <= LS_INVALID;
    end else if (rd_en_i) begin
      rd_line_o  <= upd_on_rd ? upd_line_i  : data_q[rd_index_i];
      rd_tag_o   <= upd_on_rd ? upd_tag_i   : tag_q[rd_index_i];
      rd_state_o <= upd_on_rd ? upd_state_i : state_q[rd_index_i];
    end else if (upd_on_pend) begin
      rd_line_o  <= upd_line_i;
      rd_tag_o   <= upd_tag_i;
      rd_state_o <= upd_state_i;
    end
  end
endmodule

// File: rtl/lsa_lookup.sv
module lsa_lookup #(
  parameter int TAG_W      = 22,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 16,
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic              store_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [WSEL_W-1:0] wsel_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [LINE_W-1:0] rd_line_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  logic [1:0]        rd_state_i,
  output logic [1:0]        kind_o,
  output logic [WORD_W-1:0] word_o,
  output logic [LINE_W-1:0] merged_o
);
  import lsa_pkg::*;

  logic [WORD_W-1:0] words [LINE_WORDS];
  logic              hit;

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    assign words[w] = rd_line_i[w*WORD_W +: WORD_W];
    assign merged_o[w*WORD_W +: WORD_W] =
      (wsel_i == WSEL_W'(w)) ? data_i : rd_line_i[w*WORD_W +: WORD_W];
  end

  assign hit = (rd_state_i != LS_INVALID) && (rd_tag_i == tag_i);

  always_comb begin
    word_o = '0;
    if (!hit)         kind_o = RK_MISS;
    else if (store_i) kind_o = RK_ST_HIT;
    else begin
      kind_o = RK_LD_HIT;
      word_o = words[wsel_i];
    end
  end
endmodule

// File: rtl/lsa_top.sv
module lsa_top #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 16,
  parameter int INDEX_W    = 4,
  localparam int BOFS_W    = $clog2(WORD_W / 8),
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int TAG_W     = ADDR_W - INDEX_W - WSEL_W - BOFS_W,
  localparam int LINE_W    = WORD_W * LINE_WORDS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic               req_store_i,
  input  logic [ADDR_W-1:0]  req_addr_i,
  input  logic [WORD_W-1:0]  req_data_i,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic [1:0]         rsp_kind_o,
  output logic [WORD_W-1:0]  rsp_word_o,
  output logic [LINE_W-1:0]  rsp_line_o,
  output logic [TAG_W-1:0]   rsp_tag_o,
  output logic [1:0]         rsp_status_o,
  input  logic               upd_valid_i,
  input  logic [INDEX_W-1:0] upd_index_i,
  input  logic [LINE_W-1:0]  upd_line_i,
  input  logic [TAG_W-1:0]   upd_tag_i,
  input  logic [1:0]         upd_status_i
);
  import lsa_pkg::*;

  logic [TAG_W-1:0]   a_tag;
  logic [INDEX_W-1:0] a_index;
  logic [WSEL_W-1:0]  a_wsel;

  lsa_addr_split #(
    .ADDR_W(ADDR_W), .BOFS_W(BOFS_W), .WSEL_W(WSEL_W), .INDEX_W(INDEX_W)
  ) u_split (
    .waddr_i (req_addr_i[ADDR_W-1:BOFS_W]),
    .tag_o   (a_tag),
    .index_o (a_index),
    .wsel_o  (a_wsel)
  );

  logic               pend_q, h_store_q;
  logic [TAG_W-1:0]   h_tag_q;
  logic [INDEX_W-1:0] h_index_q;
  logic [WSEL_W-1:0]  h_wsel_q;
  logic [WORD_W-1:0]  h_data_q;
  logic               accept, consume, cmt_en;
  logic [1:0]         kind;
  logic [LINE_W-1:0]  rd_line, merged;
  logic [TAG_W-1:0]   rd_tag;
  logic [1:0]         rd_state;

  assign req_ready_o = !pend_q;
  assign accept      = req_valid_i && !pend_q;
  assign consume     = pend_q && rsp_ready_i;
  assign cmt_en      = consume && (kind == RK_ST_HIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q    <= 1'b0;
      h_store_q <= 1'b0;
      h_tag_q   <= '0;
      h_index_q <= '0;
      h_wsel_q  <= '0;
      h_data_q  <= '0;
    end else if (accept) begin
      pend_q    <= 1'b1;
      h_store_q <= req_store_i;
      h_tag_q   <= a_tag;
      h_index_q <= a_index;
      h_wsel_q  <= a_wsel;
      h_data_q  <= req_data_i;
    end else if (consume) begin
      pend_q    <= 1'b0;
    end
  end

  lsa_storage #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (accept),
    .rd_index_i   (a_index),
    .pend_i       (pend_q),
    .pend_index_i (h_index_q),
    .rd_line_o    (rd_line),
    .rd_tag_o     (rd_tag),
    .rd_state_o   (rd_state),
    .cmt_en_i     (cmt_en),
    .cmt_index_i  (h_index_q),
    .cmt_line_i   (merged),
    .upd_en_i     (upd_valid_i),
    .upd_index_i  (upd_index_i),
    .upd_line_i   (upd_line_i),
    .upd_tag_i    (upd_tag_i),
    .upd_state_i  (upd_status_i)
  );

  lsa_lookup #(.TAG_W(TAG_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_look (
    .store_i    (h_store_q),
    .tag_i      (h_tag_q),
    .wsel_i     (h_wsel_q),
    .data_i     (h_data_q),
    .rd_line_i  (rd_line),
    .rd_tag_i   (rd_tag),
    .rd_state_i (rd_state),
    .kind_o     (kind),
    .word_o     (rsp_word_o),
    .merged_o   (merged)
  );

  assign rsp_valid_o  = pend_q;
  assign rsp_kind_o   = kind;
  assign rsp_line_o   = rd_line;
  assign rsp_tag_o    = rd_tag;
  assign rsp_status_o = rd_state;
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
  parameter int WORD_W = 32,
  parameter int LINE_W = 512
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [1:0]        rsp_kind_o,
  input logic [WORD_W-1:0] rsp_word_o,
  input logic [LINE_W-1:0] rsp_line_o,
  input logic [1:0]        rsp_status_o,
  input logic              upd_valid_i
);
  a_r8_rsp_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> rsp_valid_o);

  a_r8_rsp_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i && !upd_valid_i |=>
      rsp_valid_o && $stable(rsp_kind_o) && $stable(rsp_word_o) && $stable(rsp_line_o));

  a_r8_drop_after_consume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_ready_i |=> !rsp_valid_o);

  a_r6_kind_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_kind_o != 2'd3);

  a_r5_store_no_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_kind_o == 2'd1 |-> rsp_word_o == '0);

  a_r3_hit_not_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_kind_o != 2'd2 |-> rsp_status_o != 2'd0);
endmodule

bind lsa_top lsa_checker #(.WORD_W(WORD_W), .LINE_W(LINE_W)) u_chk (.*);

// File: tb/tb_lsa_top.sv
module tb_lsa_top;
  localparam int IW = 2;
  localparam int TW = 24;
  localparam int LW = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, rsp_ready = 0, upd_valid = 0;
  logic [31:0] req_addr = '0, req_data = '0;
  logic [IW-1:0] upd_index = '0;
  logic [LW-1:0] upd_line = '0;
  logic [TW-1:0] upd_tag = '0;
  logic [1:0] upd_status = '0;
  logic req_ready, rsp_valid;
  logic [1:0] rsp_kind, rsp_status;
  logic [31:0] rsp_word;
  logic [LW-1:0] rsp_line;
  logic [TW-1:0] rsp_tag;

  int n_chk = 0, n_fail = 0;
  logic [1:0] r_kind, r_status;
  logic [31:0] r_word;
  logic [LW-1:0] r_line;
  logic [TW-1:0] r_tag;
  logic r_valid, r_ready;

  lsa_top #(.INDEX_W(IW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_store_i(req_store),
    .req_addr_i(req_addr), .req_data_i(req_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_kind_o(rsp_kind),
    .rsp_word_o(rsp_word), .rsp_line_o(rsp_line), .rsp_tag_o(rsp_tag),
    .rsp_status_o(rsp_status),
    .upd_valid_i(upd_valid), .upd_index_i(upd_index), .upd_line_i(upd_line),
    .upd_tag_i(upd_tag), .upd_status_i(upd_status)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] pat(input int seed, input int idx);
    logic [LW-1:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = {8'(seed), 8'(idx), 8'(w), 8'hA5};
    return l;
  endfunction

  function automatic logic [31:0] mk(input logic [TW-1:0] tag, input int idx, input int w, input int b);
    return {tag, IW'(idx), 4'(w), 2'(b)};
  endfunction

  task automatic capture();
    r_valid = rsp_valid; r_ready = req_ready; r_kind = rsp_kind; r_word = rsp_word;
    r_line = rsp_line; r_tag = rsp_tag; r_status = rsp_status;
  endtask

  task automatic lookup(input bit st, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_store = st; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 0;
    capture();
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  task automatic upd(input int idx, input logic [LW-1:0] l, input logic [TW-1:0] t, input logic [1:0] s);
    @(negedge clk);
    upd_valid = 1; upd_index = IW'(idx); upd_line = l; upd_tag = t; upd_status = s;
    @(negedge clk);
    upd_valid = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [LW-1:0] exp_l;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 idle state after reset
    chk(req_ready == 1'b1, "R8 ready after reset", LW'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R8 no response after reset", LW'(rsp_valid), 0);
    // R1 all lines invalid
    for (int i = 0; i < 4; i++) begin
      lookup(0, mk('0, i, 0, 0), '0);
      chk(r_valid && r_kind == 2'd2, "R1 miss after reset", LW'(r_kind), 2);
      chk(r_status == 2'd0, "R1 state invalid", LW'(r_status), 0);
    end
    // R7 fill every line clean
    for (int i = 0; i < 4; i++) upd(i, pat(1, i), TW'(24'h100 + i), 2'd1);
    // R2 R4 every word of every line, byte offset varied
    for (int i = 0; i < 4; i++)
      for (int w = 0; w < 16; w++) begin
        lookup(0, mk(TW'(24'h100 + i), i, w, w % 4), '0);
        exp_l = pat(1, i);
        chk(r_kind == 2'd0, "R4 load hit kind", LW'(r_kind), 0);
        chk(r_word == exp_l[w*32 +: 32], "R2 R4 load word", LW'(r_word), LW'(exp_l[w*32 +: 32]));
      end
    // R3 R6 tag mismatch returns resident line
    for (int i = 0; i < 4; i++) begin
      lookup(0, mk(24'h200, i, 3, 0), '0);
      chk(r_kind == 2'd2, "R3 tag mismatch misses", LW'(r_kind), 2);
      chk(r_tag == TW'(24'h100 + i), "R6 miss tag", LW'(r_tag), LW'(24'h100 + i));
      chk(r_status == 2'd1, "R6 miss state clean", LW'(r_status), 1);
      chk(r_line == pat(1, i), "R6 R7 miss line", r_line, pat(1, i));
      chk(r_word == 0, "R6 miss word zero", LW'(r_word), 0);
    end
    // R5 store hit
    lookup(1, mk(24'h101, 1, 5, 0), 32'hDEADBEEF);
    chk(r_kind == 2'd1, "R5 store hit kind", LW'(r_kind), 1);
    chk(r_word == 0, "R5 store hit word zero", LW'(r_word), 0);
    lookup(0, mk(24'h101, 1, 5, 0), '0);
    chk(r_word == 32'hDEADBEEF, "R5 merged word", LW'(r_word), LW'(32'hDEADBEEF));
    lookup(0, mk(24'h200, 1, 0, 0), '0);
    exp_l = pat(1, 1); exp_l[5*32 +: 32] = 32'hDEADBEEF;
    chk(r_status == 2'd2, "R5 line dirty", LW'(r_status), 2);
    chk(r_line == exp_l, "R5 rest of line kept", r_line, exp_l);
    lookup(0, mk(24'h200, 2, 0, 0), '0);
    chk(r_status == 2'd1 && r_line == pat(1, 2), "R5 other line untouched", LW'(r_status), 1);
    // R3 matching tag but invalid state
    upd(3, pat(1, 3), TW'(24'h103), 2'd0);
    lookup(0, mk(24'h103, 3, 0, 0), '0);
    chk(r_kind == 2'd2 && r_status == 2'd0, "R3 invalid line misses", LW'(r_kind), 2);
    // R8 response holds while not consumed
    @(negedge clk);
    req_valid = 1; req_store = 0; req_addr = mk(24'h100, 0, 7, 0);
    @(negedge clk);
    req_valid = 0;
    capture();
    chk(r_valid == 1'b1, "R8 response next cycle", LW'(r_valid), 1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(rsp_valid && !req_ready && rsp_word == r_word && rsp_kind == r_kind,
          "R8 response held", LW'(rsp_word), LW'(r_word));
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk(!rsp_valid && req_ready, "R8 response dropped", LW'(rsp_valid), 0);
    // R9 update while lookup pending
    @(negedge clk);
    req_valid = 1; req_store = 0; req_addr = mk(24'h100, 0, 2, 0);
    @(negedge clk);
    req_valid = 0;
    chk(rsp_kind == 2'd0, "R9 pre-update hit", LW'(rsp_kind), 0);
    upd_valid = 1; upd_index = 0; upd_line = pat(2, 0); upd_tag = 24'h300; upd_status = 2'd1;
    @(negedge clk);
    upd_valid = 0;
    chk(rsp_kind == 2'd2 && rsp_tag == 24'h300, "R9 pending sees update", LW'(rsp_tag), LW'(24'h300));
    chk(rsp_line == pat(2, 0), "R9 pending line", rsp_line, pat(2, 0));
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    // R9 update collides with store-hit merge
    @(negedge clk);
    req_valid = 1; req_store = 1; req_addr = mk(24'h102, 2, 0, 0); req_data = 32'h11111111;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_kind == 2'd1, "R9 store hit before collision", LW'(rsp_kind), 1);
    rsp_ready = 1;
    upd_valid = 1; upd_index = 2; upd_line = pat(3, 2); upd_tag = 24'h102; upd_status = 2'd1;
    @(negedge clk);
    rsp_ready = 0; upd_valid = 0;
    lookup(0, mk(24'h200, 2, 0, 0), '0);
    chk(r_status == 2'd1, "R9 merge discarded state", LW'(r_status), 1);
    chk(r_line == pat(3, 2), "R9 merge discarded line", r_line, pat(3, 2));
    // R9 update on the cycle a lookup is accepted
    @(negedge clk);
    req_valid = 1; req_store = 0; req_addr = mk(24'h400, 1, 9, 0);
    upd_valid = 1; upd_index = 1; upd_line = pat(4, 1); upd_tag = 24'h400; upd_status = 2'd2;
    @(negedge clk);
    req_valid = 0; upd_valid = 0;
    exp_l = pat(4, 1);
    chk(rsp_kind == 2'd0 && rsp_word == exp_l[9*32 +: 32], "R9 accept sees update",
        LW'(rsp_word), LW'(exp_l[9*32 +: 32]));
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    finish_run();
  end
endmodule